// File: doc/BRIEF.md
# PWM Sequence Playback Controller

This block sits between a word memory and a PWM waveform generator and decides which duty word the generator uses, and when. Two sequences are set up independently. Each has a base address, a word count, a repeat count that holds each word for extra PWM periods, and a delay, counted in periods, that follows the last word. The waveform generator sends one pulse at the end of every PWM period. The controller uses those pulses as its time base. It fetches words over a synchronous read port with one cycle of latency and hands each word over with a one-cycle load strobe.

Software drives the block with single-cycle task pulses: stop, start sequence 0, start sequence 1 and step. A nonzero loop setting chains sequence 0 and sequence 1 and repeats the pair that many times. Five fixed shortcut paths can turn end-of-sequence or end-of-loops events into stop or start tasks, so playback can run without further tasks. Seven sticky event flags record what happened. An enable register, which can be loaded directly, set bit by bit or cleared bit by bit, selects which flags drive the interrupt line.

Top module: `pwmseq_ctrl`

## Requirements
- R1: After reset, all event flags, all interrupt enables, `irq_o`, `running_o`, `duty_o`, `duty_load_o` and `mem_rd_o` are zero.
- R2: A start task in idle raises the matching started flag (flag bit 1 for sequence 0, bit 2 for sequence 1). It then reads the words at base+0, base+1 and so on in order. Each word appears on `duty_o` with `duty_load_o` high exactly two cycles after its read strobe.
- R3: In refresh mode (`mode_step_i`=0), each word is held for repeat+1 period-end pulses, and the next word follows without a task.
- R4: In step mode (`mode_step_i`=1), period ends never advance playback. Each step task moves to the next word, or ends the sequence after the last word.
- R5: After the last word's periods, the sequence waits a further end-delay period-end pulses (none when the delay is 0). It then raises its end flag: bit 3 for sequence 0, bit 4 for sequence 1.
- R6: With a loop setting of 0, a start plays only that sequence, once. With a setting N>0, playback alternates sequence 0 and sequence 1. After the N-th pass of sequence 1 it raises loops-done (flag bit 6).
- R7: A sequence with a word count of 0 raises its started and end flags and reads no words.
- R8: A stop task during playback takes effect at the next period-end pulse. Running then drops, `duty_o` returns to 0 and the stopped flag (bit 0) is set. A stop task in idle sets the stopped flag at once.
- R9: Shortcut enable bits: bit 0 turns the end of sequence 0 into a stop, bit 1 the end of sequence 1 into a stop, bit 2 loops-done into a start of sequence 0, bit 3 loops-done into a start of sequence 1, and bit 4 loops-done into a stop.
- R10: A start task that arrives while playback is running is ignored.
- R11: Flags are sticky until a clear strobe on the same bit. A set wins over a clear in the same cycle. The period flag (bit 5) is set by period-end pulses while running.
- R12: `irq_o` is high when any flag is set together with its enable bit. The enable register is loaded by a write strobe, ORed by a set strobe and AND-NOTed by a clear strobe, with clear applied last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| task_stop_i | input | 1 | Stop task pulse |
| task_start0_i | input | 1 | Start sequence 0 task pulse |
| task_start1_i | input | 1 | Start sequence 1 task pulse |
| task_step_i | input | 1 | Step task pulse |
| mode_step_i | input | 1 | 0 refresh advance, 1 step-task advance |
| loops_i | input | LW | Loop setting |
| short_en_i | input | 5 | Shortcut enables |
| s0_base_i | input | AW | Sequence 0 base address |
| s0_len_i | input | LENW | Sequence 0 word count |
| s0_rep_i | input | REPW | Sequence 0 extra periods per word |
| s0_gap_i | input | REPW | Sequence 0 end delay |
| s1_base_i | input | AW | Sequence 1 base address |
| s1_len_i | input | LENW | Sequence 1 word count |
| s1_rep_i | input | REPW | Sequence 1 extra periods per word |
| s1_gap_i | input | REPW | Sequence 1 end delay |
| period_end_i | input | 1 | Period boundary pulse from the waveform generator |
| mem_rd_o | output | 1 | Word read strobe |
| mem_addr_o | output | AW | Word read address |
| mem_rdata_i | input | DW | Read data, valid one cycle after the strobe |
| duty_o | output | DW | Current duty word |
| duty_load_o | output | 1 | New duty word strobe |
| running_o | output | 1 | Playback active |
| flag_clr_i | input | 7 | Per-flag clear strobes |
| ie_wr_i | input | 1 | Load the enable register |
| ie_set_i | input | 1 | OR data into the enable register |
| ie_clr_i | input | 1 | Clear data bits in the enable register |
| ie_wdata_i | input | 7 | Enable write data |
| flags_o | output | 7 | Sticky event flags |
| inten_o | output | 7 | Interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the handoff after loops-done when a shortcut restarts playback. The controller then never returns to idle, and the bench cannot drain an expected-word list from it. The stimulus sets a single loop with the restart shortcut and disables the word scoreboard. It observes that running stays high and that loops-done has been raised, then ends playback with a stop task. Stop timing is checked by counting period-end pulses between the stop task and the fall of running. The count must be exactly one, whatever the phase of the stop pulse.

// File: rtl/pwmseq_pkg.sv
package pwmseq_pkg;
  localparam int NEV = 7;
  localparam int NSC = 5;

  localparam int EV_STOPPED = 0;
  localparam int EV_ST0     = 1;
  localparam int EV_ST1     = 2;
  localparam int EV_END0    = 3;
  localparam int EV_END1    = 4;
  localparam int EV_PERIOD  = 5;
  localparam int EV_LOOPS   = 6;

  localparam int SC_END0_STOP = 0;
  localparam int SC_END1_STOP = 1;
  localparam int SC_LOOP_GO0  = 2;
  localparam int SC_LOOP_GO1  = 3;
  localparam int SC_LOOP_STOP = 4;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_FETCH,
    PS_WAIT,
    PS_PLAY,
    PS_DELAY,
    PS_END,
    PS_STOP
  } pstate_t;
endpackage

// File: rtl/pwmseq_tally.sv
// Up-counter that reports when the next increment reaches a limit.
module pwmseq_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W:0]   lim_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  function automatic logic reaches(input logic [W-1:0] c, input logic [W:0] l);
    return ({1'b0, c} + {{W{1'b0}}, 1'b1}) == l;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = reaches(cnt_q, lim_i);
endmodule

// File: rtl/pwmseq_evreg.sv
// Sticky event flags, interrupt enables and interrupt line.
module pwmseq_evreg
  import pwmseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_set_i,
  input  logic [NEV-1:0] ev_clr_i,
  input  logic           ie_wr_i,
  input  logic           ie_set_i,
  input  logic           ie_clr_i,
  input  logic [NEV-1:0] ie_wdata_i,
  output logic [NEV-1:0] flags_o,
  output logic [NEV-1:0] ie_o,
  output logic           irq_o
);
  logic [NEV-1:0] flag_q;
  logic [NEV-1:0] ie_q;
  logic [NEV-1:0] ie_d;

  for (genvar g = 0; g < NEV; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q[g] <= 1'b0;
      else if (ev_set_i[g])  flag_q[g] <= 1'b1;
      else if (ev_clr_i[g])  flag_q[g] <= 1'b0;
    end
  end

  function automatic logic [NEV-1:0] ie_next(
    input logic [NEV-1:0] cur, input logic wr, input logic st,
    input logic cl, input logic [NEV-1:0] d);
    logic [NEV-1:0] v;
    v = wr ? d : cur;
    if (st) v = v | d;
    if (cl) v = v & ~d;
    return v;
  endfunction

  assign ie_d = ie_next(ie_q, ie_wr_i, ie_set_i, ie_clr_i, ie_wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie_q <= '0;
    else        ie_q <= ie_d;
  end

  assign flags_o = flag_q;
  assign ie_o    = ie_q;
  assign irq_o   = |(flag_q & ie_q);
endmodule

// File: rtl/pwmseq_fsm.sv
// Playback state machine: word fetch, repeat/delay/loop timing, shortcuts.
module pwmseq_fsm
  import pwmseq_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int LENW = 15,
  parameter int REPW = 24,
  parameter int LW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            task_stop_i,
  input  logic            task_start0_i,
  input  logic            task_start1_i,
  input  logic            task_step_i,
  input  logic            mode_step_i,
  input  logic [LW-1:0]   loops_i,
  input  logic [NSC-1:0]  short_en_i,
  input  logic [AW-1:0]   s0_base_i,
  input  logic [LENW-1:0] s0_len_i,
  input  logic [REPW-1:0] s0_rep_i,
  input  logic [REPW-1:0] s0_gap_i,
  input  logic [AW-1:0]   s1_base_i,
  input  logic [LENW-1:0] s1_len_i,
  input  logic [REPW-1:0] s1_rep_i,
  input  logic [REPW-1:0] s1_gap_i,
  input  logic            period_end_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   duty_o,
  output logic            duty_load_o,
  output logic            running_o,
  output logic [NEV-1:0]  ev_pulse_o
);
  pstate_t         st_q, st_d;
  logic            cur_q, cur_d;
  logic [LENW-1:0] idx_q, idx_d;
  logic            pend_q, pend_d;
  logic [DW-1:0]   duty_q, duty_d;
  logic            load_q, load_d;

  logic [AW-1:0]   base_c;
  logic [LENW-1:0] len_c;
  logic [REPW-1:0] rep_c, gap_c;
  logic            rep_clr, rep_inc, rep_last;
  logic            gap_clr, gap_inc, gap_last;
  logic            lp_clr, lp_inc, lp_last;
  logic            launch, launch_seq;
  logic            stop_now, advance, word_last;
  logic [NEV-1:0]  ev;

  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b, input logic [LENW-1:0] i);
    logic [AW+LENW-1:0] s;
    s = {{LENW{1'b0}}, b} + {{AW{1'b0}}, i};
    return s[AW-1:0];
  endfunction

  function automatic logic is_last(input logic [LENW-1:0] i, input logic [LENW-1:0] n);
    return ({1'b0, i} + {{LENW{1'b0}}, 1'b1}) == {1'b0, n};
  endfunction

  assign base_c    = cur_q ? s1_base_i : s0_base_i;
  assign len_c     = cur_q ? s1_len_i  : s0_len_i;
  assign rep_c     = cur_q ? s1_rep_i  : s0_rep_i;
  assign gap_c     = cur_q ? s1_gap_i  : s0_gap_i;
  assign word_last = is_last(idx_q, len_c);
  assign running_o = (st_q != PS_IDLE) && (st_q != PS_STOP);
  assign stop_now  = period_end_i && (pend_q || task_stop_i);
  assign advance   = mode_step_i ? task_step_i : (period_end_i && rep_last);

  pwmseq_tally #(.W(REPW)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr_i(rep_clr), .inc_i(rep_inc),
    .lim_i({1'b0, rep_c} + {{REPW{1'b0}}, 1'b1}), .last_o(rep_last)
  );

  pwmseq_tally #(.W(REPW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr_i(gap_clr), .inc_i(gap_inc),
    .lim_i({1'b0, gap_c}), .last_o(gap_last)
  );

  pwmseq_tally #(.W(LW)) u_loop (
    .clk(clk), .rst_n(rst_n), .clr_i(lp_clr), .inc_i(lp_inc),
    .lim_i({1'b0, loops_i}), .last_o(lp_last)
  );

  always_comb begin
    st_d = st_q;  cur_d = cur_q;  idx_d = idx_q;  pend_d = pend_q;
    duty_d = duty_q;  load_d = 1'b0;  ev = '0;
    rep_clr = 1'b0;  rep_inc = 1'b0;  gap_clr = 1'b0;  gap_inc = 1'b0;
    lp_clr = 1'b0;  lp_inc = 1'b0;  launch = 1'b0;  launch_seq = 1'b0;

    if (running_o && period_end_i) ev[EV_PERIOD] = 1'b1;
    if (running_o && task_stop_i)  pend_d = 1'b1;

    unique case (st_q)
      PS_IDLE: begin
        if (task_stop_i)         st_d = PS_STOP;
        else if (task_start0_i) begin launch = 1'b1; launch_seq = 1'b0; lp_clr = 1'b1; end
        else if (task_start1_i) begin launch = 1'b1; launch_seq = 1'b1; lp_clr = 1'b1; end
      end
      PS_FETCH: st_d = PS_WAIT;
      PS_WAIT: begin
        duty_d  = mem_rdata_i;
        load_d  = 1'b1;
        rep_clr = 1'b1;
        st_d    = PS_PLAY;
      end
      PS_PLAY: begin
        if (stop_now) st_d = PS_STOP;
        else if (advance) begin
          if (word_last) begin
            if (gap_c != '0) begin gap_clr = 1'b1; st_d = PS_DELAY; end
            else st_d = PS_END;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = PS_FETCH;
          end
        end else if (!mode_step_i && period_end_i) rep_inc = 1'b1;
      end
      PS_DELAY: begin
        if (stop_now) st_d = PS_STOP;
        else if (period_end_i) begin
          if (gap_last) st_d = PS_END;
          else gap_inc = 1'b1;
        end
      end
      PS_END: begin
        if (cur_q) ev[EV_END1] = 1'b1;
        else       ev[EV_END0] = 1'b1;
        if (pend_q || task_stop_i)                              st_d = PS_STOP;
        else if (short_en_i[cur_q ? SC_END1_STOP : SC_END0_STOP]) st_d = PS_STOP;
        else if (loops_i == '0)                                 st_d = PS_IDLE;
        else if (!cur_q) begin launch = 1'b1; launch_seq = 1'b1; end
        else if (lp_last) begin
          ev[EV_LOOPS] = 1'b1;
          lp_clr = 1'b1;
          if (short_en_i[SC_LOOP_GO0])       begin launch = 1'b1; launch_seq = 1'b0; end
          else if (short_en_i[SC_LOOP_GO1])  begin launch = 1'b1; launch_seq = 1'b1; end
          else if (short_en_i[SC_LOOP_STOP]) st_d = PS_STOP;
          else                               st_d = PS_IDLE;
        end else begin
          lp_inc = 1'b1;
          launch = 1'b1;
          launch_seq = 1'b0;
        end
      end
      PS_STOP: begin
        ev[EV_STOPPED] = 1'b1;
        duty_d = '0;
        st_d   = PS_IDLE;
      end
      default: st_d = PS_IDLE;
    endcase

    if (launch) begin
      cur_d = launch_seq;
      idx_d = '0;
      if (launch_seq) ev[EV_ST1] = 1'b1;
      else            ev[EV_ST0] = 1'b1;
      st_d = (((launch_seq ? s1_len_i : s0_len_i)) == '0) ? PS_END : PS_FETCH;
    end
    if (st_d == PS_IDLE || st_d == PS_STOP) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      cur_q  <= 1'b0;
      idx_q  <= '0;
      pend_q <= 1'b0;
      duty_q <= '0;
      load_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      duty_q <= duty_d;
      load_q <= load_d;
    end
  end

  assign mem_rd_o    = (st_q == PS_FETCH);
  assign mem_addr_o  = word_addr(base_c, idx_q);
  assign duty_o      = duty_q;
  assign duty_load_o = load_q;
  assign ev_pulse_o  = ev;
endmodule

// File: rtl/pwmseq_ctrl.sv
module pwmseq_ctrl
  import pwmseq_pkg::*;
#(
  parameter int AW   = 12,
  parameter int DW   = 16,
  parameter int LENW = 15,
  parameter int REPW = 24,
  parameter int LW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            task_stop_i,
  input  logic            task_start0_i,
  input  logic            task_start1_i,
  input  logic            task_step_i,
  input  logic            mode_step_i,
  input  logic [LW-1:0]   loops_i,
  input  logic [4:0]      short_en_i,
  input  logic [AW-1:0]   s0_base_i,
  input  logic [LENW-1:0] s0_len_i,
  input  logic [REPW-1:0] s0_rep_i,
  input  logic [REPW-1:0] s0_gap_i,
  input  logic [AW-1:0]   s1_base_i,
  input  logic [LENW-1:0] s1_len_i,
  input  logic [REPW-1:0] s1_rep_i,
  input  logic [REPW-1:0] s1_gap_i,
  input  logic            period_end_i,
  output logic            mem_rd_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   duty_o,
  output logic            duty_load_o,
  output logic            running_o,
  input  logic [6:0]      flag_clr_i,
  input  logic            ie_wr_i,
  input  logic            ie_set_i,
  input  logic            ie_clr_i,
  input  logic [6:0]      ie_wdata_i,
  output logic [6:0]      flags_o,
  output logic [6:0]      inten_o,
  output logic            irq_o
);
  logic [NEV-1:0] ev_pulse;

  pwmseq_fsm #(
    .AW(AW), .DW(DW), .LENW(LENW), .REPW(REPW), .LW(LW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .task_stop_i(task_stop_i), .task_start0_i(task_start0_i),
    .task_start1_i(task_start1_i), .task_step_i(task_step_i),
    .mode_step_i(mode_step_i), .loops_i(loops_i), .short_en_i(short_en_i),
    .s0_base_i(s0_base_i), .s0_len_i(s0_len_i), .s0_rep_i(s0_rep_i), .s0_gap_i(s0_gap_i),
    .s1_base_i(s1_base_i), .s1_len_i(s1_len_i), .s1_rep_i(s1_rep_i), .s1_gap_i(s1_gap_i),
    .period_end_i(period_end_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .duty_o(duty_o), .duty_load_o(duty_load_o), .running_o(running_o),
    .ev_pulse_o(ev_pulse)
  );

  pwmseq_evreg u_ev (
    .clk(clk), .rst_n(rst_n),
    .ev_set_i(ev_pulse), .ev_clr_i(flag_clr_i),
    .ie_wr_i(ie_wr_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .ie_wdata_i(ie_wdata_i),
    .flags_o(flags_o), .ie_o(inten_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/pwmseq_chk.sv
module pwmseq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    ev_pulse,
  input logic [6:0]    flags_o,
  input logic          mem_rd_o,
  input logic          duty_load_o,
  input logic          running_o,
  input logic [DW-1:0] duty_o
);
  // R2: every read is followed by a duty load two cycles later
  a_r2_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ##2 duty_load_o);

  // R2: only one sequence is started in any cycle
  a_r2_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_pulse[2:1]));

  // R6: loops-done only arrives together with the end of sequence 1
  a_r6_loops_with_end1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse[6] |-> ev_pulse[4]);

  // R8: no memory traffic outside playback
  a_r8_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !mem_rd_o);

  // R8: after the stopped event the outputs are idle
  a_r8_stop_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse[0] |=> (duty_o == '0) && !running_o);

  // R11: a raised event is visible as a flag in the next cycle
  a_r11_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse) |=> ((flags_o & $past(ev_pulse)) == $past(ev_pulse)));
endmodule

bind pwmseq_ctrl pwmseq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .flags_o(flags_o),
  .mem_rd_o(mem_rd_o), .duty_load_o(duty_load_o), .running_o(running_o),
  .duty_o(duty_o)
);

// File: tb/sim_pwmseq_ctrl.sv
module sim_pwmseq_ctrl;
  localparam int CLK_PER = 10;
  localparam int PE_DIV  = 6;
  localparam int WD_CYC  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_stop = 0, task_start0 = 0, task_start1 = 0, task_step = 0, mode_step = 0;
  logic [15:0] loops = '0;
  logic [4:0]  short_en = '0;
  logic [11:0] s0_base = '0, s1_base = '0;
  logic [14:0] s0_len = '0, s1_len = '0;
  logic [23:0] s0_rep = '0, s0_gap = '0, s1_rep = '0, s1_gap = '0;
  logic period_end = 1'b0;
  logic mem_rd;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [15:0] duty;
  logic duty_load, running;
  logic [6:0] flag_clr = '0, ie_wdata = '0;
  logic ie_wr = 0, ie_set = 0, ie_clr = 0;
  logic [6:0] flags, inten;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] sb[$];
  bit sb_off = 0;
  int nload = 0, pe_total = 0, fall_pe = 0, pe_cnt = 0;
  int snap[0:255];
  bit run_prev = 0;

  always #(CLK_PER/2) clk = ~clk;

  pwmseq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .task_stop_i(task_stop), .task_start0_i(task_start0), .task_start1_i(task_start1),
    .task_step_i(task_step), .mode_step_i(mode_step), .loops_i(loops), .short_en_i(short_en),
    .s0_base_i(s0_base), .s0_len_i(s0_len), .s0_rep_i(s0_rep), .s0_gap_i(s0_gap),
    .s1_base_i(s1_base), .s1_len_i(s1_len), .s1_rep_i(s1_rep), .s1_gap_i(s1_gap),
    .period_end_i(period_end),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .duty_o(duty), .duty_load_o(duty_load), .running_o(running),
    .flag_clr_i(flag_clr), .ie_wr_i(ie_wr), .ie_set_i(ie_set), .ie_clr_i(ie_clr),
    .ie_wdata_i(ie_wdata), .flags_o(flags), .inten_o(inten), .irq_o(irq)
  );

  function automatic logic [15:0] word_of(input logic [11:0] a);
    return 16'h5A00 + {4'h0, a};
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= word_of(mem_addr);

  always @(negedge clk) begin
    pe_cnt = (pe_cnt == PE_DIV-1) ? 0 : pe_cnt + 1;
    period_end = (pe_cnt == 0);
  end
  always @(posedge clk) if (period_end) pe_total = pe_total + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (duty_load) begin
      if (nload < 256) snap[nload] = pe_total;
      nload++;
      if (!sb_off) begin
        if (sb.size() == 0) chk(0, "R2 unexpected word", int'(duty), 0);
        else begin
          logic [15:0] e;
          e = sb.pop_front();
          chk(duty == e, "R2 word order", int'(duty), int'(e));
        end
      end
    end
    if (run_prev && !running) fall_pe = pe_total;
    run_prev = running;
  end

  task automatic push_seq(input logic [11:0] b, input int n);
    for (int i = 0; i < n; i++) sb.push_back(word_of(b + 12'(i)));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: task_stop = 1;  1: task_start0 = 1;  2: task_start1 = 1;  default: task_step = 1;
    endcase
    @(negedge clk);
    task_stop = 0; task_start0 = 0; task_start1 = 0; task_step = 0;
  endtask

  task automatic wait_idle();
    while (running) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [6:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic ie_op(input int op, input logic [6:0] d);
    @(negedge clk);
    ie_wdata = d; ie_wr = (op == 0); ie_set = (op == 1); ie_clr = (op == 2);
    @(negedge clk);
    ie_wr = 0; ie_set = 0; ie_clr = 0;
    @(negedge clk);
  endtask

  task automatic cfg0(input logic [11:0] b, input int n, input int r, input int g);
    s0_base = b; s0_len = 15'(n); s0_rep = 24'(r); s0_gap = 24'(g);
  endtask
  task automatic cfg1(input logic [11:0] b, input int n, input int r, input int g);
    s1_base = b; s1_len = 15'(n); s1_rep = 24'(r); s1_gap = 24'(g);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
    summary();
    $finish;
  end

  initial begin
    int b;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(flags == 0 && inten == 0 && !irq, "R1 flags/enables", {flags, inten}, 0);
    chk(!running && duty == 0 && !duty_load && !mem_rd, "R1 outputs", int'(duty), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 R3 refresh playback, no delay
    cfg0(12'd10, 3, 1, 0); loops = 0; mode_step = 0;
    b = nload; push_seq(12'd10, 3);
    pulse(1); wait_idle();
    chk(sb.size() == 0, "R2 all words played", sb.size(), 0);
    chk(snap[b+1] - snap[b] == 2, "R3 hold rep+1", snap[b+1] - snap[b], 2);
    chk(snap[b+2] - snap[b+1] == 2, "R3 hold rep+1", snap[b+2] - snap[b+1], 2);
    chk(fall_pe - snap[b+2] == 2, "R5 no delay", fall_pe - snap[b+2], 2);
    chk(flags == 7'h2A, "R11 flags after seq0", flags, 7'h2A);
    // R11 clear one flag only
    clear_flags(7'h08);
    chk(flags == 7'h22, "R11 selective clear", flags, 7'h22);
    clear_flags(7'h7f);

    // R5 end delay
    cfg0(12'd20, 2, 0, 3);
    b = nload; push_seq(12'd20, 2);
    pulse(1); wait_idle();
    chk(snap[b+1] - snap[b] == 1, "R3 rep zero", snap[b+1] - snap[b], 1);
    chk(fall_pe - snap[b+1] == 4, "R5 end delay", fall_pe - snap[b+1], 4);
    chk(flags[3], "R5 end flag", flags, 7'h08);
    clear_flags(7'h7f);

    // R6 two loops
    cfg0(12'd30, 2, 0, 0); cfg1(12'd40, 1, 0, 0); loops = 2;
    push_seq(12'd30, 2); push_seq(12'd40, 1); push_seq(12'd30, 2); push_seq(12'd40, 1);
    pulse(1); wait_idle();
    chk(sb.size() == 0, "R6 loop words", sb.size(), 0);
    chk((flags & 7'h5F) == 7'h5E, "R6 loops done flags", flags, 7'h5E);
    clear_flags(7'h7f);

    // R4 step mode
    loops = 0; mode_step = 1; cfg0(12'd50, 3, 0, 0);
    b = nload; push_seq(12'd50, 3);
    pulse(1);
    repeat (30) @(negedge clk);
    chk(nload - b == 1, "R4 no advance on periods", nload - b, 1);
    pulse(3); repeat (6) @(negedge clk);
    chk(nload - b == 2, "R4 step advances", nload - b, 2);
    pulse(3); repeat (6) @(negedge clk);
    chk(running && !flags[3], "R4 still running", flags, 0);
    pulse(3); wait_idle();
    chk(flags[3] && sb.size() == 0, "R4 end after last step", flags, 7'h08);
    mode_step = 0;
    clear_flags(7'h7f);

    // R7 zero-length sequence
    cfg1(12'd60, 0, 0, 0);
    b = nload;
    pulse(2); wait_idle();
    chk((flags & 7'h5F) == 7'h14, "R7 zero length flags", flags, 7'h14);
    chk(nload == b, "R7 no words", nload - b, 0);
    clear_flags(7'h7f);

    // R8 stop at period boundary
    cfg0(12'd70, 3, 5, 0);
    b = nload; push_seq(12'd70, 1);
    pulse(1); repeat (8) @(negedge clk);
    begin
      int p0;
      p0 = pe_total;
      pulse(0); wait_idle();
      chk(fall_pe - p0 == 1, "R8 stop at next period", fall_pe - p0, 1);
    end
    chk(flags[0] && duty == 0, "R8 stopped idle", {flags, duty}, 1);
    chk(nload - b == 1 && sb.size() == 0, "R8 no further words", nload - b, 1);
    clear_flags(7'h7f);
    pulse(0); repeat (3) @(negedge clk);
    chk(flags == 7'h01, "R8 stop in idle", flags, 7'h01);
    clear_flags(7'h7f);

    // R9 shortcut end0 -> stop
    cfg0(12'd80, 1, 0, 0); cfg1(12'd90, 1, 0, 0); loops = 1; short_en = 5'b00001;
    push_seq(12'd80, 1);
    pulse(1); wait_idle();
    chk((flags & 7'h5F) == 7'h0B, "R9 end0 stop", flags, 7'h0B);
    clear_flags(7'h7f);

    // R9 shortcut loops-done -> stop
    short_en = 5'b10000;
    push_seq(12'd80, 1); push_seq(12'd90, 1);
    pulse(1); wait_idle();
    chk((flags & 7'h5F) == 7'h5F, "R9 loops stop", flags, 7'h5F);
    clear_flags(7'h7f);

    // R9 shortcut loops-done -> start seq1 keeps running
    short_en = 5'b01000; sb_off = 1;
    pulse(1); repeat (100) @(negedge clk);
    chk(running && flags[6], "R9 loops restart", {running, flags}, 1);
    pulse(0); wait_idle();
    sb_off = 0; short_en = '0; loops = 0;
    clear_flags(7'h7f);

    // R10 start while running ignored
    cfg0(12'd100, 2, 3, 0); cfg1(12'd110, 1, 0, 0);
    push_seq(12'd100, 2);
    pulse(1); repeat (5) @(negedge clk);
    pulse(2); wait_idle();
    chk(!flags[2] && sb.size() == 0, "R10 busy start ignored", flags, 7'h0A);
    clear_flags(7'h7f);

    // R12 interrupt enables
    cfg0(12'd0, 0, 0, 0);
    pulse(1); wait_idle();
    chk(!irq, "R12 no enables", irq, 0);
    ie_op(0, 7'h08);
    chk(irq && inten == 7'h08, "R12 write enable", inten, 7'h08);
    ie_op(2, 7'h08);
    chk(!irq && inten == 0, "R12 clear enable", inten, 0);
    ie_op(1, 7'h02);
    chk(irq && inten == 7'h02, "R12 set enable", inten, 7'h02);
    @(negedge clk);
    ie_wdata = 7'h10; ie_set = 1; ie_clr = 1;
    @(negedge clk);
    ie_set = 0; ie_clr = 0;
    @(negedge clk);
    chk(inten == 7'h02, "R12 clear wins", inten, 7'h02);
    clear_flags(7'h7f);
    chk(!irq, "R12 flags cleared", irq, 0);

    summary();
    $finish;
  end
endmodule